// File: doc/BRIEF.md
# Power-Domain Reset Generator

This block turns digitized supply status into the resets of a chip with a battery-backed domain and a switched main rail. It watches a main-rail power-good level and a battery-ok comparator output. From these it drives three resets. The first clears battery-powered state. The second is an active-low power-on reset for main-rail logic. The third is an active-low system reset, which also responds to a watchdog request and to an external active-low reset pin.

The battery-domain reset depends on the state of the main rail. Suppose the rail comes up and the battery reads low: the reset then fires as a short pulse. Suppose instead the rail is down and a good cell is inserted: the reset then rises and holds until the rail returns. While the rail is up, battery changes have no effect on this reset.

An optional selector also produces a host platform reset. It picks between a legacy platform-reset pin and a platform reset delivered over eSPI, and it forces the result asserted while the rail is down. An always-on reset input initialises the block's own flops. The clock is assumed to run from the always-on supply.

Top module: `pwr_rst_gen`

## Requirements
- R1: When the synchronized main rail rises and the synchronized battery-ok is low (and no insertion level is held), `batt_rst_o` is high for exactly 2 clock cycles. The rail passes through 2 synchronizer flops, so the pulse begins after the 3rd rising clock edge that follows `rail_good_i` going high.
- R2: While the rail is down, a low-to-high change of `batt_ok_i` sets `batt_rst_o` high as a held level. The level becomes visible after the 3rd clock edge that follows the change.
- R3: A held insertion level on `batt_rst_o` is released when the synchronized rail rises. `batt_rst_o` goes low after the 3rd clock edge that follows `rail_good_i` rising.
- R4: While the main rail stays up, changes of `batt_ok_i` in either direction leave `batt_rst_o` low.
- R5: `rail_por_n_o` goes high after the 2nd clock edge that follows `rail_good_i` rising.
- R6: `rail_por_n_o` goes low at once, without waiting for a clock edge, whenever `rail_good_i` is low.
- R7: `sys_rst_n_o` is low whenever `rail_por_n_o` is low or `ext_rst_n_i` is low.
- R8: A watchdog request held for w cycles keeps `sys_rst_n_o` low for w+15 cycles, counted from the first clock edge that samples the request. This gives a minimum stretch of 16 cycles.
- R9: `host_rst_n_o` equals `espi_prst_n_i` when `host_sel_i` is 1 and equals `legacy_prst_n_i` when `host_sel_i` is 0. It is forced low while `rail_good_i` is low.
- R10: When an insertion level is held and the rail rises while battery-ok is low, the held level wins. `batt_rst_o` is released as in R3, and no power-up pulse follows.
- R11: While `aon_rst_n` is low and the rail is down, `batt_rst_o`, `rail_por_n_o`, `sys_rst_n_o` and `host_rst_n_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| aon_rst_n | input | 1 | Active-low reset for the block's own flops |
| rail_good_i | input | 1 | Main-rail power-good level, asynchronous |
| batt_ok_i | input | 1 | Battery voltage above threshold, asynchronous |
| wdt_req_i | input | 1 | Watchdog reset request |
| ext_rst_n_i | input | 1 | External active-low reset pin |
| legacy_prst_n_i | input | 1 | Legacy platform reset, active low |
| espi_prst_n_i | input | 1 | Platform reset received over eSPI, active low |
| host_sel_i | input | 1 | 1 selects the eSPI platform reset, 0 selects the legacy pin |
| batt_rst_o | output | 1 | Battery-domain reset, active high |
| rail_por_n_o | output | 1 | Main-rail power-on reset, active low |
| sys_rst_n_o | output | 1 | Combined system reset, active low |
| host_rst_n_o | output | 1 | Selected host platform reset, active low |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 2-cycle power-up pulse, a 16-cycle watchdog stretch and the host selector enabled. A stretch this short lets the bench sweep several request widths and check the exact cycle on which the system reset is released. The same settings give fixed, countable latencies for the pulse and the held level, so each can be checked cycle by cycle. The host selector is checked over every combination of select and input levels, once with the rail up and again with the rail down.

// File: rtl/pwr_rst_gen.sv
module pwr_rst_gen #(
  parameter int SYNC_STAGES    = 2,
  parameter int PULSE_CYCLES   = 2,
  parameter int WDT_MIN_CYCLES = 16,
  parameter bit HOST_MUX_EN    = 1'b1
) (
  input  logic clk,
  input  logic aon_rst_n,
  input  logic rail_good_i,
  input  logic batt_ok_i,
  input  logic wdt_req_i,
  input  logic ext_rst_n_i,
  input  logic legacy_prst_n_i,
  input  logic espi_prst_n_i,
  input  logic host_sel_i,
  output logic batt_rst_o,
  output logic rail_por_n_o,
  output logic sys_rst_n_o,
  output logic host_rst_n_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam int WW = $clog2(WDT_MIN_CYCLES + 1);

  logic [SYNC_STAGES-1:0] rail_sync;
  logic [SYNC_STAGES-1:0] batt_sync;
  logic rail_clr_n, rg, bk, rg_prev, bk_prev, hold_q;
  logic rail_rise, cell_ins, pulse_go;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] wcnt;

  assign rail_clr_n = rail_good_i & aon_rst_n;

  always_ff @(posedge clk or negedge rail_clr_n)
    if (!rail_clr_n) rail_sync <= '0;
    else             rail_sync <= {rail_sync[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge aon_rst_n)
    if (!aon_rst_n) batt_sync <= '1;
    else            batt_sync <= {batt_sync[SYNC_STAGES-2:0], batt_ok_i};

  assign rg = rail_sync[SYNC_STAGES-1];
  assign bk = batt_sync[SYNC_STAGES-1];

  assign rail_rise = rg & ~rg_prev;
  assign cell_ins  = ~rg & bk & ~bk_prev;
  assign pulse_go  = rail_rise & ~bk & ~hold_q;

  always_ff @(posedge clk or negedge aon_rst_n)
    if (!aon_rst_n) begin
      rg_prev <= 1'b0;
      bk_prev <= 1'b1;
      hold_q  <= 1'b0;
      pcnt    <= '0;
    end else begin
      rg_prev <= rg;
      bk_prev <= bk;
      if (rail_rise)     hold_q <= 1'b0;
      else if (cell_ins) hold_q <= 1'b1;
      if (pulse_go)         pcnt <= PW'(PULSE_CYCLES);
      else if (pcnt != '0)  pcnt <= pcnt - 1'b1;
    end

  assign batt_rst_o   = hold_q | (pcnt != '0);
  assign rail_por_n_o = rg;

  always_ff @(posedge clk or negedge aon_rst_n)
    if (!aon_rst_n)      wcnt <= '0;
    else if (wdt_req_i)  wcnt <= WW'(WDT_MIN_CYCLES);
    else if (wcnt != '0) wcnt <= wcnt - 1'b1;

  assign sys_rst_n_o = rg & ext_rst_n_i & (wcnt == '0);

  generate
    if (HOST_MUX_EN) begin : g_host_mux
      assign host_rst_n_o = rg & (host_sel_i ? espi_prst_n_i : legacy_prst_n_i);
    end else begin : g_host_por
      assign host_rst_n_o = rg;
    end
  endgenerate

  // R1
  pup_pulse_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    pulse_go |=> batt_rst_o);
  // R2
  cell_level_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (!rg && $rose(bk)) |=> batt_rst_o);
  // R3
  hold_release_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (hold_q && $rose(rg)) |=> !hold_q);
  // R10
  hold_wins_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (hold_q && $rose(rg) && !bk) |=> !batt_rst_o);
  // R4
  rail_up_quiet_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (rg && $past(rg) && $past(rg, 2) && $past(rg, 3)) |-> !batt_rst_o);
  // R6
  por_low_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !rail_good_i |-> !rail_por_n_o);
  // R7
  ext_pin_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !ext_rst_n_i |-> !sys_rst_n_o);
  // R8
  wdt_stretch_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    wdt_req_i |=> !sys_rst_n_o);
  // R9
  host_forced_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !rail_good_i |-> !host_rst_n_o);
endmodule

// File: tb/pwr_rst_gen_tb.sv
module pwr_rst_gen_tb;
  logic clk = 1'b0;
  logic aon_rst_n, rail_good, batt_ok, wdt_req, ext_rst_n, leg, espi, sel;
  logic batt_rst, por_n, sys_n, host_n;
  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  pwr_rst_gen u_dut (
    .clk(clk), .aon_rst_n(aon_rst_n), .rail_good_i(rail_good), .batt_ok_i(batt_ok),
    .wdt_req_i(wdt_req), .ext_rst_n_i(ext_rst_n), .legacy_prst_n_i(leg),
    .espi_prst_n_i(espi), .host_sel_i(sel), .batt_rst_o(batt_rst),
    .rail_por_n_o(por_n), .sys_rst_n_o(sys_n), .host_rst_n_o(host_n));

  task automatic check(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    aon_rst_n = 0; rail_good = 0; batt_ok = 0; wdt_req = 0;
    ext_rst_n = 1; leg = 1; espi = 1; sel = 0;
    cyc(4);
    check("R11 batt", batt_rst, 1'b0);
    check("R11 por", por_n, 1'b0);
    check("R11 sys", sys_n, 1'b0);
    check("R11 host", host_n, 1'b0);
    aon_rst_n = 1;
    cyc(4);

    // R1 and R5: power-up with low battery
    rail_good = 1;
    for (int k = 1; k <= 8; k++) begin
      cyc(1);
      check("R1 pulse", batt_rst, (k == 3 || k == 4));
      check("R5 por release", por_n, k >= 2);
    end

    // R4: battery changes with rail up
    for (int p = 0; p < 4; p++) begin
      batt_ok = ~p[0];
      for (int k = 0; k < 6; k++) begin
        cyc(1);
        check("R4 ignore", batt_rst, 1'b0);
      end
    end

    // R9 and R7 sweeps with rail up
    for (int v = 0; v < 8; v++) begin
      sel = v[2]; espi = v[1]; leg = v[0];
      #1 check("R9 mux", host_n, v[2] ? v[1] : v[0]);
      cyc(1);
    end
    for (int e = 0; e < 2; e++) begin
      ext_rst_n = e[0];
      #1 check("R7 ext", sys_n, e[0]);
      cyc(1);
    end

    // R8: watchdog request widths
    for (int w = 1; w <= 3; w++) begin
      wdt_req = 1;
      for (int k = 1; k <= w + 18; k++) begin
        cyc(1);
        check("R8 stretch", sys_n, k > w + 15);
        if (k == w) wdt_req = 0;
      end
    end

    // R6, R7, R9: rail falls
    leg = 1; espi = 1;
    rail_good = 0;
    #1;
    check("R6 por", por_n, 1'b0);
    check("R7 sys", sys_n, 1'b0);
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      #1 check("R9 forced", host_n, 1'b0);
    end

    // R2 and R3: cell inserted while rail down
    cyc(1);
    batt_ok = 0;
    cyc(4);
    batt_ok = 1;
    for (int k = 1; k <= 16; k++) begin
      cyc(1);
      check("R2 level", batt_rst, k >= 3);
    end
    rail_good = 1;
    for (int k = 1; k <= 6; k++) begin
      cyc(1);
      check("R3 release", batt_rst, k <= 2);
    end

    // R10: held level with low battery at rail rise
    rail_good = 0;
    batt_ok = 0;
    cyc(4);
    check("R10 idle", batt_rst, 1'b0);
    batt_ok = 1;
    cyc(6);
    batt_ok = 0;
    cyc(4);
    check("R10 held", batt_rst, 1'b1);
    rail_good = 1;
    for (int k = 1; k <= 7; k++) begin
      cyc(1);
      check("R10 precedence", batt_rst, k <= 2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule